// File: doc/BRIEF.md
# Handshake-Terminated Bus Cycle Master

This block turns one internal transfer request into the strobe sequence of an asynchronous 16-bit bus. Each request carries a byte address, a 3-bit function code, a read/write flag, a size (byte, word or long word) and up to 32 bits of write data. The block drives the word address, function code, the read/write line, an address strobe and two data strobes, one for each byte lane. It then waits for the slave to end the cycle with an acknowledge or a bus-error input. When the transfer is over it reports a one-cycle completion with an error flag and the assembled read data.

The block runs on a state clock whose period equals one bus state, which is half a bus clock. A plain cycle therefore takes eight ticks. While the termination inputs are absent at the sampling point, the block stays in the sampling state in steps of two ticks, one whole bus clock per step. A long word is carried as two word cycles, the upper half first at the lower address. A byte uses address bit 0 to choose its lane. The block opens no new cycle while the slave still holds either termination input low.

Top module: `asb_master`

## Requirements
- R1: After reset both data strobes, the address strobe and the completion output are high, high, high and low. The read/write line is high (read), and `req_ready` is high while both termination inputs are released.
- R2: A word read whose acknowledge is present at the first sampling point holds the address strobe low for 5 ticks. `rsp_done` pulses high 9 ticks after the edge that accepted the request, and `rsp_rdata[15:0]` carries the bus data latched at the end of the strobe window.
- R3: Each sampling point that finds neither termination input low adds two ticks to the address strobe window and to the completion time.
- R4: A byte transfer asserts only the upper strobe (`bus_uds_n`, lane bits 15:8) for an even address and only the lower strobe (`bus_lds_n`, bits 7:0) for an odd address. A byte read returns the selected lane in `rsp_rdata[7:0]`, with the upper bits zero.
- R5: Word and long-word transfers assert both data strobes. A long word runs two cycles, the second at the next word address. It returns the first word in `rsp_rdata[31:16]` and the second in `rsp_rdata[15:0]`, and it completes 17 ticks after acceptance when no waits occur.
- R6: A write drives `bus_rw` low and `bus_doe` high for 5 ticks, from the tick after the address strobe falls through the tick in which the strobes are released. The data strobes are low for 3 ticks, inside that window. Word data goes out from `req_wdata[15:0]`, a byte from `req_wdata[7:0]` on both lanes, and a long word sends `req_wdata[31:16]` first.
- R7: A cycle ended by bus error without acknowledge completes with `rsp_err` high and `rsp_rdata` zero, at the same time an acknowledged cycle would complete.
- R8: A bus error in the first half of a long word abandons the second half. Only one address strobe window occurs, and the error is reported.
- R9: While either termination input is still low after a cycle, `req_ready` stays low and no new address strobe starts. The next cycle begins on the tick after the release is seen.
- R10: While the address strobe is low, the address, function code and read/write line stay stable, and neither data strobe is low unless the address strobe is low.
- R11: An acknowledge that arrives together with bus error counts as a normal completion, with valid data and `rsp_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock, one period per bus state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle and bus released; request accepted when both high |
| req_addr | input | AW | Byte address of the transfer |
| req_fc | input | FC_W | Function code for the cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = byte, 1 = word, 2 = long word |
| req_wdata | input | 32 | Write data, right-aligned for byte and word |
| rsp_done | output | 1 | One-tick completion pulse |
| rsp_err | output | 1 | Transfer ended by bus error, valid with rsp_done |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| bus_addr | output | AW-1 | Word address (byte address bits above bit 0) |
| bus_fc | output | FC_W | Function code on the bus |
| bus_rw | output | 1 | High for read, low during a write cycle |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper lane strobe (even byte, bits 15:8), active low |
| bus_lds_n | output | 1 | Lower lane strobe (odd byte, bits 7:0), active low |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data from the bus |
| bus_dtack_n | input | 1 | Data acknowledge from the slave, active low |
| bus_berr_n | input | 1 | Bus error from the slave, active low |

## Verification
Counting from the edge that accepts a request, the completion pulse is due 9 ticks later for a single cycle and 17 ticks later for a long word. Each wait step adds 2 ticks, and a slave that keeps its acknowledge low after a cycle adds 1 tick per extra tick held. The bench measures that distance at falling edges, so it samples in mid-tick, and compares it with those exact figures. It counts the low ticks of each strobe and of the write enable in the same way: 5 for the address strobe, 3 for write data strobes, and 5 for the drive enable. Address, function code and written data are captured by the bench's slave model in the tick where the strobe falls or the lane strobe is low, and they are checked only after completion.

// File: rtl/asb_pkg.sv
package asb_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2
   } asb_size_e;

   typedef enum logic [3:0] {
      ST_IDLE = 4'd0,
      ST_S0   = 4'd1,
      ST_S1   = 4'd2,
      ST_S2   = 4'd3,
      ST_S3   = 4'd4,
      ST_S4   = 4'd5,
      ST_S5   = 4'd6,
      ST_S6   = 4'd7,
      ST_S7   = 4'd8,
      ST_HOLD = 4'd9
   } asb_state_e;

endpackage

// File: rtl/asb_sync.sv
module asb_sync #(
   parameter int STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] d,
   output logic [1:0] q
);
   if (STAGES < 0 || STAGES > 3) begin : g_bad_stages
      $error("asb_sync: STAGES must be 0..3");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_pipe
      logic [1:0] pipe [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= 2'b11;
         end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         end
      end
      assign q = pipe[STAGES-1];
   end
endmodule

// File: rtl/asb_lane.sv
module asb_lane
   import asb_pkg::*;
#(
   parameter int BUS_W = 16
) (
   input  asb_size_e            size,
   input  logic                 b0,
   input  logic                 half,
   input  logic [2*BUS_W-1:0]   wdata,
   input  logic [BUS_W-1:0]     din,
   output logic                 use_u,
   output logic                 use_l,
   output logic [BUS_W-1:0]     dout,
   output logic [BUS_W-1:0]     rd_slice
);
   localparam int HB = BUS_W / 2;

   if (BUS_W % 2 != 0) begin : g_bad_width
      $error("asb_lane: BUS_W must be even");
   end

   always_comb begin
      use_u    = 1'b1;
      use_l    = 1'b1;
      dout     = wdata[BUS_W-1:0];
      rd_slice = din;
      case (size)
         SZ_BYTE: begin
            use_u    = ~b0;
            use_l    = b0;
            dout     = {wdata[HB-1:0], wdata[HB-1:0]};
            rd_slice = {{HB{1'b0}}, (b0 ? din[HB-1:0] : din[BUS_W-1:HB])};
         end
         SZ_LONG: begin
            dout = half ? wdata[BUS_W-1:0] : wdata[2*BUS_W-1:BUS_W];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/asb_seq.sv
module asb_seq
   import asb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic is_write,
   input  logic is_long,
   input  logic dtack_n,
   input  logic berr_n,
   output logic ready,
   output logic accept,
   output logic active,
   output logic as_on,
   output logic ds_on,
   output logic doe_on,
   output logic cap,
   output logic adv,
   output logic fin,
   output logic err,
   output logic half
);
   asb_state_e st;
   logic       wph;
   logic       ack_q;
   logic       released;
   logic       more;

   assign released = dtack_n & berr_n;
   assign ready    = (st == ST_IDLE) & released;
   assign accept   = ready & req_valid;
   assign more     = is_long & ~half & ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         wph   <= 1'b0;
         half  <= 1'b0;
         ack_q <= 1'b0;
         err   <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (accept) begin
               st    <= ST_S0;
               half  <= 1'b0;
               ack_q <= 1'b0;
               err   <= 1'b0;
            end
            ST_S0: st <= ST_S1;
            ST_S1: st <= ST_S2;
            ST_S2: st <= ST_S3;
            ST_S3: st <= ST_S4;
            ST_S4: begin
               if (wph) begin
                  wph <= 1'b0;
               end else if (!dtack_n || !berr_n) begin
                  st    <= ST_S5;
                  ack_q <= ~dtack_n;
                  err   <= dtack_n;
               end else begin
                  wph <= 1'b1;
               end
            end
            ST_S5: st <= ST_S6;
            ST_S6: st <= ST_S7;
            ST_S7: begin
               if (more) begin
                  half  <= 1'b1;
                  ack_q <= 1'b0;
                  st    <= released ? ST_S0 : ST_HOLD;
               end else begin
                  st <= ST_IDLE;
               end
            end
            ST_HOLD: if (released) st <= ST_S0;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      active = st inside {ST_S0, ST_S1, ST_S2, ST_S3, ST_S4, ST_S5, ST_S6, ST_S7};
      as_on  = st inside {ST_S2, ST_S3, ST_S4, ST_S5, ST_S6};
      ds_on  = is_write ? (st inside {ST_S4, ST_S5, ST_S6}) : as_on;
      doe_on = is_write & (st inside {ST_S3, ST_S4, ST_S5, ST_S6, ST_S7});
      cap    = (st == ST_S6) & ack_q & ~is_write;
      adv    = (st == ST_S7) & more;
      fin    = (st == ST_S7) & ~more;
   end
endmodule

// File: rtl/asb_master.sv
module asb_master
   import asb_pkg::*;
#(
   parameter int AW          = 24,
   parameter int FC_W        = 3,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [AW-1:0]     req_addr,
   input  logic [FC_W-1:0]   req_fc,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [31:0]       req_wdata,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata,
   output logic [AW-1:1]     bus_addr,
   output logic [FC_W-1:0]   bus_fc,
   output logic              bus_rw,
   output logic              bus_as_n,
   output logic              bus_uds_n,
   output logic              bus_lds_n,
   output logic [15:0]       bus_dout,
   output logic              bus_doe,
   input  logic [15:0]       bus_din,
   input  logic              bus_dtack_n,
   input  logic              bus_berr_n
);
   localparam int BUS_W = 16;
   localparam int REQ_W = 2 * BUS_W;
   localparam logic [AW-2:0] WORD_STEP = 1;

   if (AW < 4) begin : g_bad_aw
      $error("asb_master: AW must be at least 4");
   end
   if (FC_W < 1) begin : g_bad_fc
      $error("asb_master: FC_W must be at least 1");
   end

   logic [AW-2:0]      waddr_q;
   logic               b0_q;
   logic [FC_W-1:0]    fc_q;
   logic               wr_q;
   asb_size_e          size_q;
   logic [REQ_W-1:0]   wdata_q;
   logic [REQ_W-1:0]   rbuf;

   logic [1:0] term_n;
   logic accept, active, as_on, ds_on, doe_on, cap, adv, fin, seq_err, half;
   logic use_u, use_l;
   logic [BUS_W-1:0] rd_slice;

   asb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bus_berr_n, bus_dtack_n}),
      .q     (term_n)
   );

   asb_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .is_write  (wr_q),
      .is_long   (size_q == SZ_LONG),
      .dtack_n   (term_n[0]),
      .berr_n    (term_n[1]),
      .ready     (req_ready),
      .accept    (accept),
      .active    (active),
      .as_on     (as_on),
      .ds_on     (ds_on),
      .doe_on    (doe_on),
      .cap       (cap),
      .adv       (adv),
      .fin       (fin),
      .err       (seq_err),
      .half      (half)
   );

   asb_lane #(.BUS_W(BUS_W)) u_lane (
      .size     (size_q),
      .b0       (b0_q),
      .half     (half),
      .wdata    (wdata_q),
      .din      (bus_din),
      .use_u    (use_u),
      .use_l    (use_l),
      .dout     (bus_dout),
      .rd_slice (rd_slice)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waddr_q   <= '0;
         b0_q      <= 1'b0;
         fc_q      <= '0;
         wr_q      <= 1'b0;
         size_q    <= SZ_WORD;
         wdata_q   <= '0;
         rbuf      <= '0;
         rsp_done  <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         if (accept) begin
            waddr_q <= req_addr[AW-1:1];
            b0_q    <= req_addr[0];
            fc_q    <= req_fc;
            wr_q    <= req_write;
            size_q  <= asb_size_e'(req_size);
            wdata_q <= req_wdata;
            rbuf    <= '0;
         end else if (adv) begin
            waddr_q <= waddr_q + WORD_STEP;
         end
         if (cap) begin
            if (size_q == SZ_LONG && !half) rbuf[REQ_W-1:BUS_W] <= rd_slice;
            else                            rbuf[BUS_W-1:0]     <= rd_slice;
         end
         rsp_done <= fin;
         rsp_err  <= fin & seq_err;
         if (fin) rsp_rdata <= seq_err ? '0 : rbuf;
      end
   end

   assign bus_addr  = waddr_q;
   assign bus_fc    = fc_q;
   assign bus_rw    = ~(active & wr_q);
   assign bus_as_n  = ~as_on;
   assign bus_uds_n = ~(ds_on & use_u);
   assign bus_lds_n = ~(ds_on & use_l);
   assign bus_doe   = doe_on;
endmodule

// File: rtl/asb_master_chk.sv
module asb_master_chk
   import asb_pkg::*;
#(
   parameter int AW   = 24,
   parameter int FC_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic [AW-1:1]   bus_addr,
   input logic [FC_W-1:0] bus_fc,
   input logic            bus_rw,
   input logic            bus_as_n,
   input logic            bus_uds_n,
   input logic            bus_lds_n,
   input logic            bus_doe,
   input logic            bus_dtack_n,
   input logic            bus_berr_n,
   input logic            rsp_done,
   input logic            rsp_err,
   input logic [31:0]     rsp_rdata,
   input asb_size_e       size_q
);
   AST_DS_INSIDE_AS: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_uds_n || !bus_lds_n) |-> !bus_as_n); // R10

   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_as_n && $past(!bus_as_n)) |-> ($stable(bus_addr) && $stable(bus_fc) && $stable(bus_rw))); // R10

   AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_uds_n && !bus_lds_n) |-> (size_q != SZ_BYTE)); // R4

   AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rw && (!bus_uds_n || !bus_lds_n)) |-> bus_doe); // R6

   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_done && rsp_rdata == 32'd0)); // R7

   AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_as_n && (!bus_dtack_n || !bus_berr_n)) |=> bus_as_n); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R2
endmodule

bind asb_master asb_master_chk #(.AW(AW), .FC_W(FC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_fc      (bus_fc),
   .bus_rw      (bus_rw),
   .bus_as_n    (bus_as_n),
   .bus_uds_n   (bus_uds_n),
   .bus_lds_n   (bus_lds_n),
   .bus_doe     (bus_doe),
   .bus_dtack_n (bus_dtack_n),
   .bus_berr_n  (bus_berr_n),
   .rsp_done    (rsp_done),
   .rsp_err     (rsp_err),
   .rsp_rdata   (rsp_rdata),
   .size_q      (size_q)
);

// File: tb/asb_master_test.sv
`timescale 1ns/1ps
module asb_master_test;
   localparam int AW = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [2:0]    req_fc = '0;
   logic          req_write = 1'b0;
   logic [1:0]    req_size = 2'd1;
   logic [31:0]   req_wdata = '0;
   logic          rsp_done, rsp_err;
   logic [31:0]   rsp_rdata;
   logic [AW-1:1] bus_addr;
   logic [2:0]    bus_fc;
   logic          bus_rw, bus_as_n, bus_uds_n, bus_lds_n, bus_doe;
   logic [15:0]   bus_dout, bus_din;
   logic          bus_dtack_n = 1'b1;
   logic          bus_berr_n = 1'b1;

   function automatic logic [15:0] rdf(input logic [AW-1:1] w);
      rdf = 16'h5A00 ^ {w[8:1], ~w[8:1]};
   endfunction
   assign bus_din = rdf(bus_addr);

   asb_master #(.AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_fc(req_fc), .req_write(req_write), .req_size(req_size),
      .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_rw(bus_rw), .bus_as_n(bus_as_n),
      .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
      .bus_din(bus_din), .bus_dtack_n(bus_dtack_n), .bus_berr_n(bus_berr_n)
   );

   // slave model: mode bit0 = acknowledge, bit1 = bus error
   int s_mode = 1, s_dly = 1, s_hold = 0;
   int lowcnt = 0, hold_left = 0;
   int as_cnt, u_cnt, l_cnt, doe_cnt, starts;
   logic as_prev = 1'b1;
   logic [AW-1:1] acap [2];
   logic [2:0]    fcap [2];
   logic          rwcap [2];
   logic [15:0]   wcap [2];

   always @(negedge clk) begin
      as_prev <= bus_as_n;
      if (!bus_as_n) begin
         as_cnt <= as_cnt + 1;
         lowcnt <= lowcnt + 1;
         if (lowcnt + 1 >= s_dly) begin
            bus_dtack_n <= ~s_mode[0];
            bus_berr_n  <= ~s_mode[1];
            hold_left   <= s_hold;
         end
         if (as_prev && starts < 2) begin
            acap[starts]  <= bus_addr;
            fcap[starts]  <= bus_fc;
            rwcap[starts] <= bus_rw;
            starts <= starts + 1;
         end
      end else begin
         lowcnt <= 0;
         if (!bus_dtack_n || !bus_berr_n) begin
            if (hold_left > 0) hold_left <= hold_left - 1;
            else begin
               bus_dtack_n <= 1'b1;
               bus_berr_n  <= 1'b1;
            end
         end
      end
      if (!bus_uds_n) u_cnt <= u_cnt + 1;
      if (!bus_lds_n) l_cnt <= l_cnt + 1;
      if (bus_doe) doe_cnt <= doe_cnt + 1;
      if ((!bus_uds_n || !bus_lds_n) && starts > 0) wcap[starts-1] <= bus_dout;
   end

   int n_chk = 0, n_bad = 0;
   int res_lat;
   logic [31:0] res_rd;
   logic res_err;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic run(input logic [AW-1:0] a, input logic [2:0] fc, input logic wr,
                      input logic [1:0] sz, input logic [31:0] wd,
                      input int mode, input int dly, input int hold);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      as_cnt = 0; u_cnt = 0; l_cnt = 0; doe_cnt = 0; starts = 0;
      wcap[0] = '0; wcap[1] = '0;
      s_mode = mode; s_dly = dly; s_hold = hold;
      req_addr = a; req_fc = fc; req_write = wr; req_size = sz; req_wdata = wd;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      res_lat = 1;
      while (!rsp_done && res_lat < 300) begin
         @(negedge clk);
         res_lat++;
      end
      res_rd = rsp_rdata;
      res_err = rsp_err;
      #1;
   endtask

   task automatic t_reset;
      check(bus_as_n && bus_uds_n && bus_lds_n, "R1 strobes idle",
            {29'd0, bus_as_n, bus_uds_n, bus_lds_n}, 32'd7);
      check(bus_rw == 1'b1 && rsp_done == 1'b0, "R1 rw/done", {30'd0, bus_rw, rsp_done}, 32'd2);
      check(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);
   endtask

   task automatic t_read_word;
      run(24'h000420, 3'd5, 1'b0, 2'd1, 32'd0, 1, 1, 0);
      check(res_lat == 9, "R2 latency", res_lat, 9);
      check(as_cnt == 5, "R2 strobe window", as_cnt, 5);
      check(res_rd == {16'd0, rdf(23'h000210)}, "R2 read data", res_rd, {16'd0, rdf(23'h000210)});
      check(u_cnt == 5 && l_cnt == 5, "R5 word both lanes", {u_cnt[15:0], l_cnt[15:0]}, 32'h0005_0005);
      check(acap[0] == 23'h000210 && fcap[0] == 3'd5 && rwcap[0] == 1'b1, "R10 address/fc/rw",
            {5'd0, acap[0], fcap[0], rwcap[0]}, {5'd0, 23'h000210, 3'd5, 1'b1});
      check(res_err == 1'b0, "R2 no error", {31'd0, res_err}, 0);
   endtask

   task automatic t_wait;
      run(24'h000100, 3'd1, 1'b0, 2'd1, 32'd0, 1, 4, 0);
      check(res_lat == 11 && as_cnt == 7, "R3 one wait step", {res_lat[15:0], as_cnt[15:0]}, 32'h000B_0007);
      run(24'h000102, 3'd1, 1'b0, 2'd1, 32'd0, 1, 7, 0);
      check(res_lat == 13 && as_cnt == 9, "R3 two wait steps", {res_lat[15:0], as_cnt[15:0]}, 32'h000D_0009);
      check(res_rd == {16'd0, rdf(23'h000081)}, "R3 data after waits", res_rd, {16'd0, rdf(23'h000081)});
   endtask

   task automatic t_byte_read;
      logic [15:0] w = rdf(23'h000918);
      run(24'h001230, 3'd2, 1'b0, 2'd0, 32'd0, 1, 1, 0);
      check(u_cnt == 5 && l_cnt == 0, "R4 even byte upper lane", {u_cnt[15:0], l_cnt[15:0]}, 32'h0005_0000);
      check(res_rd == {24'd0, w[15:8]}, "R4 even byte data", res_rd, {24'd0, w[15:8]});
      run(24'h001231, 3'd2, 1'b0, 2'd0, 32'd0, 1, 1, 0);
      check(u_cnt == 0 && l_cnt == 5, "R4 odd byte lower lane", {u_cnt[15:0], l_cnt[15:0]}, 32'h0000_0005);
      check(res_rd == {24'd0, w[7:0]}, "R4 odd byte data", res_rd, {24'd0, w[7:0]});
   endtask

   task automatic t_long_read;
      run(24'h000C40, 3'd6, 1'b0, 2'd2, 32'd0, 1, 1, 0);
      check(res_lat == 17 && starts == 2, "R5 long two cycles", {res_lat[15:0], starts[15:0]}, 32'h0011_0002);
      check(acap[1] == acap[0] + 23'd1, "R5 second address", {9'd0, acap[1]}, {9'd0, acap[0] + 23'd1});
      check(res_rd == {rdf(23'h000620), rdf(23'h000621)}, "R5 long data", res_rd,
            {rdf(23'h000620), rdf(23'h000621)});
   endtask

   task automatic t_write;
      run(24'h002000, 3'd1, 1'b1, 2'd1, 32'h0000_BEEF, 1, 1, 0);
      check(rwcap[0] == 1'b0 && doe_cnt == 5, "R6 rw and drive window", {15'd0, rwcap[0], doe_cnt[15:0]}, 32'h0000_0005);
      check(u_cnt == 3 && l_cnt == 3, "R6 write strobe window", {u_cnt[15:0], l_cnt[15:0]}, 32'h0003_0003);
      check(wcap[0] == 16'hBEEF, "R6 word data", {16'd0, wcap[0]}, 32'h0000_BEEF);
      run(24'h002005, 3'd1, 1'b1, 2'd0, 32'h0000_00C3, 1, 1, 0);
      check(u_cnt == 0 && l_cnt == 3 && wcap[0][7:0] == 8'hC3, "R6 odd byte write",
            {u_cnt[7:0], l_cnt[7:0], 8'd0, wcap[0][7:0]}, 32'h0003_00C3);
      run(24'h003000, 3'd1, 1'b1, 2'd2, 32'h1234_5678, 1, 1, 0);
      check(wcap[0] == 16'h1234 && wcap[1] == 16'h5678, "R6 long write order",
            {wcap[0], wcap[1]}, 32'h1234_5678);
   endtask

   task automatic t_berr;
      run(24'h000500, 3'd1, 1'b0, 2'd1, 32'd0, 2, 1, 0);
      check(res_err == 1'b1 && res_rd == 32'd0 && res_lat == 9, "R7 bus error",
            {res_lat[15:0], 15'd0, res_err} | res_rd, 32'h0009_0001);
      run(24'h000500, 3'd1, 1'b0, 2'd1, 32'd0, 3, 1, 0);
      check(res_err == 1'b0 && res_rd == {16'd0, rdf(23'h000280)}, "R11 ack with bus error",
            res_rd, {16'd0, rdf(23'h000280)});
      run(24'h000600, 3'd1, 1'b0, 2'd2, 32'd0, 2, 1, 0);
      check(starts == 1 && res_err == 1'b1, "R8 long abandoned", {starts[15:0], 15'd0, res_err}, 32'h0001_0001);
   endtask

   task automatic t_release;
      int n;
      run(24'h000700, 3'd1, 1'b0, 2'd1, 32'd0, 1, 1, 4);
      check(req_ready == 1'b0 && bus_dtack_n == 1'b0, "R9 ready low while held",
            {30'd0, req_ready, bus_dtack_n}, 32'd0);
      n = 0;
      while (!req_ready && n < 20) begin
         @(negedge clk);
         #1;
         n++;
         if (!bus_as_n) check(1'b0, "R9 strobe while held", 0, 1);
      end
      check(n == 3, "R9 release delay", n, 3);
      run(24'h000800, 3'd1, 1'b0, 2'd2, 32'd0, 1, 1, 3);
      check(res_lat == 20, "R9 long held between halves", res_lat, 20);
      check(res_rd == {rdf(23'h000400), rdf(23'h000401)}, "R9 long data after hold", res_rd,
            {rdf(23'h000400), rdf(23'h000401)});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      t_reset();
      t_read_word();
      t_wait();
      t_byte_read();
      t_long_read();
      t_write();
      t_berr();
      t_release();
      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule